// File: doc/BRIEF.md
# Single-Cycle Register and Arithmetic Datapath

This block is the execute portion of a single-cycle 64-bit processor, driven entirely by externally supplied control fields. Each cycle it reads two source registers from a 32-entry register file, forms the second operand from either a register or a 64-bit immediate, and computes one of five arithmetic or shift operations. On the rising clock edge it writes the result to the destination register. Alongside the register file it keeps a program counter that steps by 4 each cycle.

Entry 0 of the register file always reads as zero and cannot be written. A synchronous clear zeroes the program counter and every register on the next rising edge, and it takes priority over any write. Registers 5 and 6 are always visible at dedicated outputs, so a sequence of hand-driven operations can be observed without a read port.

Top module: `exec_datapath`

## Requirements
- R1: While `rst_n` is low, the program counter and all registers are zero; `reg5_q`, `reg6_q` and `pc_q` read 0.
- R2: On each rising edge with `clr` low, `pc_q` becomes its previous value plus 4, modulo 2^64.
- R3: On a rising edge with `clr` high, `pc_q` and every register become zero, whatever `wr_en` is.
- R4: With `clr` low and `wr_en` high, destination register `dst_sel` takes the operation result on the rising edge. No other register changes. With `wr_en` low, no register changes.
- R5: Register 0 always reads as zero, and writes to it are discarded.
- R6: `op_sel` encoding: 3'b000 add and 3'b001 subtract (A minus B), both wrapping modulo 2^64. 3'b010 multiply, keeping the low 64 bits of the product.
- R7: 3'b011 shifts A left and 3'b100 shifts A right logically (zero fill). In both cases the shift amount is B[5:0].
- R8: `op_sel` values 3'b101, 3'b110 and 3'b111 give a result of zero.
- R9: `b_imm_sel`=0 takes operand B from the register chosen by `src1_sel`. `b_imm_sel`=1 takes it from `imm`. Operand A always comes from the register chosen by `src0_sel`.
- R10: Adding an immediate of all ones (-1) to a zero register yields 64'hFFFF_FFFF_FFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the program counter and all registers |
| src0_sel | input | 5 | Register index for operand A |
| src1_sel | input | 5 | Register index for operand B when the register source is chosen |
| dst_sel | input | 5 | Destination register index |
| wr_en | input | 1 | Write enable for the destination register |
| b_imm_sel | input | 1 | Operand B source: 0 register, 1 immediate |
| op_sel | input | 3 | Operation code |
| imm | input | 64 | Immediate operand |
| reg5_q | output | 64 | Contents of register 5 |
| reg6_q | output | 64 | Contents of register 6 |
| pc_q | output | 64 | Program counter |

## Verification
Every result is due exactly one rising edge after its stimulus. An operation applied before edge N shows on `reg5_q` or `reg6_q` right after edge N, and so does a clear or a program counter step. Operations whose destination is not 5 or 6 are observed by a later copy operation into register 5 or 6, such as adding zero. The bench drives inputs at the falling edge. Its reference model updates on the same rising edge as the design, and all three outputs are compared at the next falling edge.

// File: rtl/exec_datapath_pkg.sv
package exec_datapath_pkg;
  localparam int XLEN     = 64;
  localparam int NREGS    = 32;
  localparam int SEL_W    = $clog2(NREGS);
  localparam int SHAMT_W  = $clog2(XLEN);
  localparam int PC_STEP  = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MUL = 3'b010,
    OP_SHL = 3'b011,
    OP_SHR = 3'b100
  } alu_op_e;
endpackage

// File: rtl/dp_alu.sv
module dp_alu
  import exec_datapath_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   op,
  output logic [W-1:0] res
);
  localparam int SH_W = $clog2(W);
  logic [SH_W-1:0] shamt;
  assign shamt = opb[SH_W-1:0];

  always_comb begin
    unique case (op)
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_MUL:  res = opa * opb;
      OP_SHL:  res = opa << shamt;
      OP_SHR:  res = opa >> shamt;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (op > 3'b100) assert_undef_zero_R8: assert (res == '0);
  end
endmodule

// File: rtl/dp_pc.sv
module dp_pc
  import exec_datapath_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int STEP = PC_STEP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] pc
);
  logic [W-1:0] pc_d;

  always_comb begin
    if (clr) pc_d = '0;
    else     pc_d = pc + W'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_d;
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> pc == $past(pc) + W'(STEP));
  assert_pc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pc == '0);
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
  import exec_datapath_pkg::*;
#(
  parameter int W = XLEN,
  parameter int N = NREGS,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [SW-1:0] rsel0,
  input  logic [SW-1:0] rsel1,
  input  logic [SW-1:0] wsel,
  input  logic          we,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata0,
  output logic [W-1:0]  rdata1,
  output logic [W-1:0]  tap5,
  output logic [W-1:0]  tap6
);
  logic [W-1:0] regs [N];
  logic [N-1:0] wen_oh;

  always_comb begin
    wen_oh = '0;
    if (we) wen_oh[wsel] = 1'b1;
    wen_oh[0] = 1'b0;
  end

  assign regs[0] = '0;

  for (genvar i = 1; i < N; i++) begin : g_reg
    logic [W-1:0] d;
    logic         en;
    assign en = wen_oh[i] | clr;
    assign d  = clr ? '0 : wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[i] <= '0;
      else if (en) regs[i] <= d;
    end
  end

  assign rdata0 = regs[rsel0];
  assign rdata1 = regs[rsel1];
  assign tap5   = regs[5];
  assign tap6   = regs[6];

  always_comb begin
    if (rsel0 == '0) assert_zero_read_R5: assert (rdata0 == '0);
  end
  assert_hold_no_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(tap5) && $stable(tap6));
  assert_clear_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> tap5 == '0 && tap6 == '0);
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_datapath_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] src0_sel,
  input  logic [SEL_W-1:0] src1_sel,
  input  logic [SEL_W-1:0] dst_sel,
  input  logic             wr_en,
  input  logic             b_imm_sel,
  input  logic [2:0]       op_sel,
  input  logic [XLEN-1:0]  imm,
  output logic [XLEN-1:0]  reg5_q,
  output logic [XLEN-1:0]  reg6_q,
  output logic [XLEN-1:0]  pc_q
);
  logic [XLEN-1:0] rd0, rd1, opb, result;

  dp_pc #(.W(XLEN), .STEP(PC_STEP)) pc_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pc(pc_q)
  );

  dp_regfile #(.W(XLEN), .N(NREGS)) rf_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rsel0(src0_sel), .rsel1(src1_sel), .wsel(dst_sel), .we(wr_en),
    .wdata(result), .rdata0(rd0), .rdata1(rd1), .tap5(reg5_q), .tap6(reg6_q)
  );

  assign opb = b_imm_sel ? imm : rd1;

  dp_alu #(.W(XLEN)) alu_i (
    .opa(rd0), .opb(opb), .op(op_sel), .res(result)
  );

  assert_write5_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && dst_sel == 5'd5) |=> reg5_q == $past(result));
  assert_imm_add_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && dst_sel == 5'd6 && src0_sel == 5'd0 && b_imm_sel &&
     op_sel == 3'b000 && imm == '1) |=> reg6_q == '1);
endmodule

// File: tb/exec_datapath_tb.sv
module exec_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [4:0] s0 = '0, s1 = '0, ds = '0;
  logic we = 1'b0, bsel = 1'b0;
  logic [2:0] op = '0;
  logic [63:0] imm = '0;
  logic [63:0] r5, r6, pc;

  int n_run = 0, n_fail = 0;
  logic [63:0] mreg [32];
  logic [63:0] mpc;

  always #2.5 clk = ~clk;

  exec_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .src0_sel(s0), .src1_sel(s1),
    .dst_sel(ds), .wr_en(we), .b_imm_sel(bsel), .op_sel(op), .imm(imm),
    .reg5_q(r5), .reg6_q(r6), .pc_q(pc)
  );

  function automatic logic [63:0] model_alu(logic [63:0] a, logic [63:0] b, logic [2:0] o);
    int sh = int'(b[5:0]);
    case (o)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a * b;
      3'd3: return a << sh;
      3'd4: return a >> sh;
      default: return 64'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      logic [63:0] a, b;
      a = (s0 == 0) ? 64'd0 : mreg[s0];
      b = bsel ? imm : ((s1 == 0) ? 64'd0 : mreg[s1]);
      if (clr) begin
        mpc = 0;
        for (int i = 0; i < 32; i++) mreg[i] = 0;
      end else begin
        mpc = mpc + 64'd4;
        if (we && ds != 0) mreg[ds] = model_alu(a, b, op);
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk({tag, " reg5"}, r5, mreg[5]);
    chk({tag, " reg6"}, r6, mreg[6]);
    chk({tag, " pc"}, pc, mpc);
  endtask

  task automatic step(string tag, logic c, logic [4:0] a0, logic [4:0] a1,
                      logic [4:0] d, logic w, logic bs, logic [2:0] o, logic [63:0] im);
    clr = c; s0 = a0; s1 = a1; ds = d; we = w; bsel = bs; op = o; imm = im;
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic li(string tag, logic [4:0] d, logic [63:0] v);
    step(tag, 0, 0, 0, d, 1, 1, 3'd0, v);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    mpc = 0;
    repeat (3) @(negedge clk);
    cmp_all("R1 reset");
    rst_n = 1'b1;
    step("R2 pc step idle", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R10 t0=x0+(-1)", 0, 0, 0, 5, 1, 1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 all ones", r5, 64'hFFFF_FFFF_FFFF_FFFF);
    li("R9 li t1", 6, 64'd2);
    step("R6 add wrap", 0, 5, 6, 5, 1, 0, 3'd0, 0);
    chk("R6 wrap value", r5, 64'd1);
    li("R6 li t0", 5, 64'd5);
    li("R6 li t1", 6, 64'd3);
    step("R6 sub", 0, 5, 6, 5, 1, 0, 3'd1, 0);
    step("R6 sub negative", 0, 6, 0, 6, 1, 1, 3'd1, 64'd10);
    step("R6 mul", 0, 5, 6, 5, 1, 0, 3'd2, 0);
    li("R7 li t1", 6, 64'h8000_0000_0000_0001);
    step("R7 shl imm", 0, 6, 0, 5, 1, 1, 3'd3, 64'd65);
    step("R7 shr imm", 0, 6, 0, 6, 1, 1, 3'd4, 64'd63);
    li("R7 li t0", 5, 64'hF0);
    step("R7 shr reg", 0, 5, 6, 5, 1, 0, 3'd4, 0);
    for (int o = 5; o < 8; o++) begin
      li("R8 preload", 5, 64'h1234);
      step("R8 undefined op", 0, 5, 5, 5, 1, 1, 3'(o), 64'h55);
    end
    li("R4 li t0", 5, 64'h77);
    step("R4 write x9", 0, 5, 0, 9, 1, 1, 3'd0, 64'd1);
    step("R4 we low", 0, 5, 0, 5, 0, 1, 3'd0, 64'd99);
    step("R4 copy x9", 0, 9, 0, 6, 1, 1, 3'd0, 64'd0);
    chk("R4 x9 value", r6, 64'h78);
    step("R5 write x0", 0, 5, 0, 0, 1, 1, 3'd0, 64'd5);
    step("R5 read x0", 0, 0, 0, 6, 1, 1, 3'd0, 64'd0);
    chk("R5 zero read", r6, 64'd0);
    li("R3 preload", 6, 64'hABCD);
    step("R3 clear with write", 1, 5, 0, 5, 1, 1, 3'd0, 64'd42);
    chk("R3 pc zero", pc, 64'd0);
    step("R3 copy x9 after clear", 0, 9, 0, 6, 1, 1, 3'd0, 0);
    chk("R3 x9 cleared", r6, 64'd0);
    for (int k = 0; k < 5; k++) step("R2 pc run", 0, 0, 0, 0, 0, 0, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule